// File: doc/BRIEF.md
# Flash Byte Program Engine with Read-Back Verify

This engine writes a run of bytes into a single 64 KiB erase block of a byte-wide command-set flash, then reads the whole run back and compares it with the source. A caller supplies an absolute start address, a length and a one-cycle-latency source buffer. The engine first trims the length so the run stops at the end of the block that holds the start address. It then programs each byte through the device's command interface and polls the status register. It recovers from a device that stays busy and from program errors. Once every byte is stored and a settle delay has passed, it compares the device contents with the buffer.

A bridge in front of the flash needs the byte lane given separately from the word-aligned bus address. The engine therefore drives a lane register. The flash sits behind a write gate that closes by itself, so the engine asks for a gate kick before every gated command. All delays are counted in clock cycles derived from a cycles-per-millisecond parameter. The result is a one-cycle completion pulse with a result code and a byte count.

Top module: `flash_prog_engine`

## Requirements
- R1: The run length used is min(start_len, 65536 - start_addr[15:0]). A run that ends exactly on the block end is not shortened.
- R2: For each byte, lane_sel is loaded with bits [1:0] of the byte address no later than the gate kick that precedes the program command. The program command 0x40 and then the data byte are written to the byte address with bits [1:0] forced to zero.
- R3: After the data byte, 0x70 is written to the block base address, and reads at the block base repeat until a status byte with bit 7 set is returned. fl_wr and fl_rd are never high together.
- R4: If bit 7 is not seen within BYTE_WAIT_MS*CYC_PER_MS cycles of the status command, the engine writes 0x50 and programs the same byte again.
- R5: Once the status is ready, 0xFF is written before any other command. If status bit 4 was set, 0x50 follows it.
- R6: After a program error, if fewer than BLOCK_WAIT_MS*CYC_PER_MS cycles have passed since start, the engine waits PAUSE_MS and reprograms the same byte. Otherwise it completes with res_code 2 (timeout) and res_count 0.
- R7: After the last byte, the engine waits PAUSE_MS, then reads back each byte and compares it with the buffer. Any mismatch completes with res_code 1 (verify failure) and res_count 0.
- R8: A clean run completes with a one-cycle done pulse, res_code 0 and res_count equal to the clipped length. res_code 3 never occurs.
- R9: kick_req is high in the cycle just before every bus write of 0x40, 0x50 or 0xFF used as a command.
- R10: start is ignored while busy is high. A request whose clipped length is zero completes with res_code 0 and res_count 0 and makes no bus access. busy is low in the done cycle.
- R11: After reset, busy, done, kick_req, fl_wr and fl_rd are low and lane_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| start_addr | input | ADDR_W | Absolute byte address of the first byte |
| start_len | input | BLK_W+1 | Requested byte count |
| busy | output | 1 | Engine working on a request |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 2 | 0 ok, 1 verify failure, 2 timeout |
| res_count | output | BLK_W+1 | Bytes committed (0 on failure) |
| src_idx | output | BLK_W | Source buffer read index |
| src_data | input | 8 | Buffer byte, valid the cycle after src_idx is presented |
| fl_wr | output | 1 | Flash bus write strobe |
| fl_rd | output | 1 | Flash bus read strobe |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 8 | Flash bus write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_rd |
| lane_sel | output | 2 | Byte lane for the bridge |
| kick_req | output | 1 | Write-gate kick request pulse |

## Verification
A single status read can carry the ready bit and the program-error bit together. The engine must then restore read-array mode first and only afterwards clear the error. The device model flags any clear-status that arrives while read mode is still pending. Fault injection also lets an error be detected in the same cycle window in which the block deadline runs out: a persistent error forces the deadline to be reached at an error check, and the run must end as a timeout with no byte count. The model also counts program attempts per job, so each retry path is judged by the exact number of extra attempts it causes.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_VERIFY  = 2'd1,
    RES_TIMEOUT = 2'd2
  } fpe_res_e;

  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;

  typedef enum logic [4:0] {
    S_IDLE, S_FETCH, S_LOAD, S_KPROG, S_CMD, S_DATA, S_RSTAT,
    S_POLL, S_PW1, S_PW2, S_KTCLR, S_TCLR, S_KARR, S_ARR,
    S_KCLR, S_CLR, S_PAUSE, S_SETTLE, S_VRD, S_VW1, S_VCMP
  } fpe_state_e;
endpackage

// File: rtl/fpe_clip.sv
module fpe_clip #(
  parameter int BLK_W = 16,
  parameter int CNT_W = BLK_W + 1
) (
  input  logic [BLK_W-1:0] offset,
  input  logic [CNT_W-1:0] req_len,
  output logic [CNT_W-1:0] run_len
);
  localparam logic [CNT_W-1:0] BLK_BYTES = CNT_W'(1) << BLK_W;

  logic [CNT_W-1:0] room;

  always_comb begin
    room    = BLK_BYTES - {{(CNT_W-BLK_W){1'b0}}, offset};
    run_len = (req_len > room) ? room : req_len;
  end
endmodule

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter longint unsigned LIMIT = 64'd16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 64'd1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int BLK_W         = 16,
  parameter int CYC_PER_MS    = 100000,
  parameter int BYTE_WAIT_MS  = 1000,
  parameter int BLOCK_WAIT_MS = 30000,
  parameter int PAUSE_MS      = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [BLK_W:0]      start_len,
  output logic                busy,
  output logic                done,
  output logic [1:0]          res_code,
  output logic [BLK_W:0]      res_count,
  output logic [BLK_W-1:0]    src_idx,
  input  logic [7:0]          src_data,
  output logic                fl_wr,
  output logic                fl_rd,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [7:0]          fl_wdata,
  input  logic [7:0]          fl_rdata,
  output logic [1:0]          lane_sel,
  output logic                kick_req
);
  localparam int CNT_W = BLK_W + 1;
  localparam longint unsigned BYTE_CYC  = 64'(BYTE_WAIT_MS)  * 64'(CYC_PER_MS);
  localparam longint unsigned BLOCK_CYC = 64'(BLOCK_WAIT_MS) * 64'(CYC_PER_MS);
  localparam longint unsigned PAUSE_CYC = 64'(PAUSE_MS)      * 64'(CYC_PER_MS);

  fpe_state_e st, st_n;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  len_q;
  logic [BLK_W-1:0]  idx, idx_n;
  logic [7:0]        dbyte;
  logic              err_q;

  logic [CNT_W-1:0]  clip_len;
  logic [ADDR_W-1:0] cur_addr, word_addr, blk_base;
  logic              last_byte;

  logic              byte_exp, blk_exp, pause_exp;

  logic              wr_n, rd_n, kick_n;
  logic [ADDR_W-1:0] addr_n;
  logic [7:0]        wd_n;
  logic              finish;
  fpe_res_e          fin_code;
  logic [CNT_W-1:0]  fin_cnt;

  fpe_clip #(.BLK_W(BLK_W), .CNT_W(CNT_W)) clip_i (
    .offset  (start_addr[BLK_W-1:0]),
    .req_len (start_len),
    .run_len (clip_len)
  );

  fpe_timer #(.LIMIT(BYTE_CYC)) byte_tmr_i (
    .clk(clk), .rst(rst),
    .clr(!(st inside {S_POLL, S_PW1, S_PW2})),
    .expired(byte_exp)
  );

  fpe_timer #(.LIMIT(BLOCK_CYC)) blk_tmr_i (
    .clk(clk), .rst(rst),
    .clr(st == S_IDLE),
    .expired(blk_exp)
  );

  fpe_timer #(.LIMIT(PAUSE_CYC)) pause_tmr_i (
    .clk(clk), .rst(rst),
    .clr(!(st inside {S_PAUSE, S_SETTLE})),
    .expired(pause_exp)
  );

  always_comb begin
    cur_addr  = base_q + ADDR_W'(idx);
    word_addr = {cur_addr[ADDR_W-1:2], 2'b00};
    blk_base  = {base_q[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
    last_byte = ({1'b0, idx} == (len_q - 1'b1));
  end

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    wr_n     = 1'b0;
    rd_n     = 1'b0;
    kick_n   = 1'b0;
    addr_n   = blk_base;
    wd_n     = 8'h00;
    finish   = 1'b0;
    fin_code = RES_OK;
    fin_cnt  = '0;
    case (st)
      S_IDLE: begin
        if (start) begin
          idx_n = '0;
          if (clip_len == '0) finish = 1'b1;
          else                st_n   = S_FETCH;
        end
      end
      S_FETCH: st_n = S_LOAD;
      S_LOAD:  st_n = S_KPROG;
      S_KPROG: begin kick_n = 1'b1; st_n = S_CMD; end
      S_CMD: begin
        wr_n = 1'b1; addr_n = word_addr; wd_n = CMD_PROG; st_n = S_DATA;
      end
      S_DATA: begin
        wr_n = 1'b1; addr_n = word_addr; wd_n = dbyte; st_n = S_RSTAT;
      end
      S_RSTAT: begin wr_n = 1'b1; wd_n = CMD_STAT; st_n = S_POLL; end
      S_POLL:  begin rd_n = 1'b1; st_n = S_PW1; end
      S_PW1:   st_n = S_PW2;
      S_PW2: begin
        if (fl_rdata[7])   st_n = S_KARR;
        else if (byte_exp) st_n = S_KTCLR;
        else               st_n = S_POLL;
      end
      S_KTCLR: begin kick_n = 1'b1; st_n = S_TCLR; end
      S_TCLR:  begin wr_n = 1'b1; wd_n = CMD_CLR; st_n = S_KPROG; end
      S_KARR:  begin kick_n = 1'b1; st_n = S_ARR; end
      S_ARR: begin
        wr_n = 1'b1; wd_n = CMD_ARRAY;
        if (err_q)          st_n = S_KCLR;
        else if (last_byte) begin st_n = S_SETTLE; idx_n = '0; end
        else                begin st_n = S_FETCH;  idx_n = idx + 1'b1; end
      end
      S_KCLR: begin kick_n = 1'b1; st_n = S_CLR; end
      S_CLR: begin
        wr_n = 1'b1; wd_n = CMD_CLR;
        if (blk_exp) begin
          finish = 1'b1; fin_code = RES_TIMEOUT; st_n = S_IDLE;
        end else begin
          st_n = S_PAUSE;
        end
      end
      S_PAUSE:  if (pause_exp) st_n = S_KPROG;
      S_SETTLE: if (pause_exp) st_n = S_VRD;
      S_VRD: begin rd_n = 1'b1; addr_n = cur_addr; st_n = S_VW1; end
      S_VW1: st_n = S_VCMP;
      S_VCMP: begin
        if (fl_rdata != src_data) begin
          finish = 1'b1; fin_code = RES_VERIFY; st_n = S_IDLE;
        end else if (last_byte) begin
          finish = 1'b1; fin_code = RES_OK; fin_cnt = len_q; st_n = S_IDLE;
        end else begin
          idx_n = idx + 1'b1; st_n = S_VRD;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      base_q    <= '0;
      len_q     <= '0;
      idx       <= '0;
      dbyte     <= '0;
      err_q     <= 1'b0;
      lane_sel  <= 2'd0;
      fl_wr     <= 1'b0;
      fl_rd     <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      kick_req  <= 1'b0;
      done      <= 1'b0;
      res_code  <= 2'd0;
      res_count <= '0;
    end else begin
      st       <= st_n;
      idx      <= idx_n;
      fl_wr    <= wr_n;
      fl_rd    <= rd_n;
      fl_addr  <= addr_n;
      fl_wdata <= wd_n;
      kick_req <= kick_n;
      done     <= finish;
      if (st == S_IDLE && start) begin
        base_q <= start_addr;
        len_q  <= clip_len;
      end
      if (st == S_LOAD)  dbyte    <= src_data;
      if (st == S_KPROG) lane_sel <= cur_addr[1:0];
      if (st == S_PW2 && fl_rdata[7]) err_q <= fl_rdata[4];
      if (finish) begin
        res_code  <= fin_code;
        res_count <= fin_cnt;
      end
    end
  end

  assign busy    = (st != S_IDLE);
  assign src_idx = idx;
endmodule

// File: rtl/fpe_checks.sv
module fpe_checks #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [1:0]       res_code,
  input logic [CNT_W-1:0] res_count,
  input logic             fl_wr,
  input logic             fl_rd,
  input logic [1:0]       fl_addr_lo,
  input logic [7:0]       fl_wdata,
  input logic [1:0]       lane_sel,
  input logic             kick_req
);
  logic after_prog;

  always_ff @(posedge clk) begin
    if (rst) after_prog <= 1'b0;
    else if (fl_wr) after_prog <= (fl_wdata == 8'h40) && !after_prog;
  end

  assert_gate_kick_R9: assert property (@(posedge clk) disable iff (rst)
    (fl_wr && !after_prog &&
     (fl_wdata == 8'h40 || fl_wdata == 8'h50 || fl_wdata == 8'hFF))
    |-> $past(kick_req));

  assert_cmd_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (fl_wr && (after_prog || fl_wdata == 8'h40)) |-> (fl_addr_lo == 2'b00));

  assert_lane_with_kick_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane_sel) |-> kick_req);

  assert_bus_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_wr, fl_rd}));

  assert_fail_no_count_R6: assert property (@(posedge clk) disable iff (rst)
    (done && res_code != 2'd0) |-> (res_count == '0));

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_code != 2'd3));

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind flash_prog_engine fpe_checks #(.CNT_W(BLK_W + 1)) fpe_checks_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .res_code   (res_code),
  .res_count  (res_count),
  .fl_wr      (fl_wr),
  .fl_rd      (fl_rd),
  .fl_addr_lo (fl_addr[1:0]),
  .fl_wdata   (fl_wdata),
  .lane_sel   (lane_sel),
  .kick_req   (kick_req)
);

// File: tb/flash_prog_engine_tb_top.sv
module flash_prog_engine_tb_top;
  localparam int ADDR_W = 20;
  localparam int BLK_W  = 16;
  localparam int CNT_W  = BLK_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  start_len = '0;
  logic              busy, done;
  logic [1:0]        res_code;
  logic [CNT_W-1:0]  res_count;
  logic [BLK_W-1:0]  src_idx;
  logic [7:0]        src_data = 8'h00;
  logic              fl_wr, fl_rd;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_wdata;
  logic [7:0]        fl_rdata = 8'h00;
  logic [1:0]        lane_sel;
  logic              kick_req;

  always #5 clk = ~clk;

  flash_prog_engine #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CYC_PER_MS(2),
    .BYTE_WAIT_MS(8), .BLOCK_WAIT_MS(150), .PAUSE_MS(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .res_code(res_code),
    .res_count(res_count), .src_idx(src_idx), .src_data(src_data),
    .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .lane_sel(lane_sel), .kick_req(kick_req)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // source buffer, one cycle read latency
  logic [7:0] sbuf [0:1023];
  always @(posedge clk) src_data <= sbuf[src_idx[9:0]];

  // flash device model
  logic [7:0] fmem [int];
  int  prog_cnt = 0, job_base = 0, hang_n = 0, err_n = 0, slow = 0;
  int  corrupt_addr = -1;
  int  gate_viol = 0, align_viol = 0, order_viol = 0, bus_ops = 0;
  bit  pend = 0, mode_stat = 0, st_err = 0, need_ff = 0, kick_d = 0;
  int  busy_left = 0;

  always @(posedge clk) begin
    kick_d <= kick_req;
    if (rst) begin
      pend <= 0; mode_stat <= 0; st_err <= 0; need_ff <= 0; busy_left <= 0;
    end else if (fl_rd) begin
      bus_ops++;
      if (mode_stat) begin
        if (busy_left > 0) begin
          busy_left <= busy_left - 1;
          fl_rdata  <= 8'h00;
        end else begin
          fl_rdata <= st_err ? 8'h90 : 8'h80;
          if (st_err) need_ff <= 1;
        end
      end else begin
        fl_rdata <= fmem.exists(int'(fl_addr)) ? fmem[int'(fl_addr)] : 8'hFF;
      end
    end else if (fl_wr) begin
      bus_ops++;
      if (pend) begin
        int a;
        int k;
        a = int'({fl_addr[ADDR_W-1:2], lane_sel});
        k = prog_cnt - job_base;
        prog_cnt++;
        pend <= 0;
        mode_stat <= 1;
        if (fl_addr[1:0] != 2'b00) align_viol++;
        if (k < hang_n) begin
          busy_left <= 1000; st_err <= 0;
        end else if (k < hang_n + err_n) begin
          busy_left <= slow; st_err <= 1;
        end else begin
          busy_left <= slow; st_err <= 0;
          fmem[a] = (a == corrupt_addr) ? (fl_wdata ^ 8'h5A) : fl_wdata;
        end
      end else begin
        case (fl_wdata)
          8'h40: begin
            if (!kick_d) gate_viol++;
            if (fl_addr[1:0] != 2'b00) align_viol++;
            pend <= 1;
          end
          8'h70: mode_stat <= 1;
          8'h50: begin
            if (!kick_d) gate_viol++;
            if (need_ff) order_viol++;
            st_err <= 0;
          end
          8'hFF: begin
            if (!kick_d) gate_viol++;
            mode_stat <= 0; need_ff <= 0;
          end
          default: gate_viol++;
        endcase
      end
    end
  end

  // scoreboard
  typedef struct { int code; int cnt; } exp_t;
  exp_t exp_q[$];
  int   done_cnt = 0;

  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(res_code) == e.code, "R8 result code", res_code, e.code);
        chk(int'(res_count) == e.cnt, "R1 result count", res_count, e.cnt);
      end
    end
  end

  function automatic int clip(input int addr, input int len);
    int room;
    room = 65536 - (addr & 16'hFFFF);
    return (len > room) ? room : len;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) sbuf[i] = 8'((i * 37 + seed * 11) ^ (i >> 3));
  endtask

  task automatic run_job(input int addr, input int len, input int ecode, input int ecnt);
    int d0;
    exp_t e;
    d0 = done_cnt;
    e.code = ecode; e.cnt = ecnt;
    exp_q.push_back(e);
    job_base = prog_cnt;
    @(negedge clk);
    start_addr = ADDR_W'(addr);
    start_len  = CNT_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_mem(input int addr, input int cnt, input string tag);
    bit ok;
    ok = 1;
    for (int i = 0; i < cnt; i++)
      if (!fmem.exists(addr + i) || fmem[addr + i] != sbuf[i]) ok = 0;
    chk(ok, tag, ok, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int ops0, p0;
    fill(1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
    chk(!kick_req && !fl_wr && !fl_rd, "R11 bus idle after reset", {kick_req, fl_wr, fl_rd}, 0);
    chk(lane_sel == 2'd0, "R11 lane after reset", lane_sel, 0);

    // R2 R3 R8: plain run, unaligned start so every lane is used
    fill(2); slow = 2;
    run_job(32'h10103, 8, 0, 8);
    chk_mem(32'h10103, 8, "R2 contents of plain run");
    chk(prog_cnt - job_base == 8, "R3 one attempt per byte", prog_cnt - job_base, 8);

    // R1 clip at block end
    fill(3); slow = 0;
    run_job(32'h1FFFC, 10, 0, clip(32'h1FFFC, 10));
    chk_mem(32'h1FFFC, 4, "R1 clipped contents");
    chk(!fmem.exists(32'h20000), "R1 nothing past block end", fmem.exists(32'h20000), 0);

    // R1 run ending exactly on the boundary
    fill(4);
    run_job(32'h2FFF8, 8, 0, clip(32'h2FFF8, 8));
    chk_mem(32'h2FFF8, 8, "R1 boundary-exact contents");
    chk(!fmem.exists(32'h30000), "R1 boundary-exact no spill", fmem.exists(32'h30000), 0);

    // R1 oversize request
    fill(5);
    run_job(32'h4FFFE, 65536, 0, 2);

    // R4 ready wait timeout then retry
    fill(6); hang_n = 1; slow = 1;
    run_job(32'h50001, 1, 0, 1);
    chk(prog_cnt - job_base == 2, "R4 timeout causes one reprogram", prog_cnt - job_base, 2);
    chk_mem(32'h50001, 1, "R4 byte stored after retry");
    hang_n = 0;

    // R5 R6 program error retried inside the deadline
    fill(7); err_n = 2;
    run_job(32'h50011, 2, 0, 2);
    chk(prog_cnt - job_base == 4, "R6 error retries", prog_cnt - job_base, 4);
    chk_mem(32'h50011, 2, "R6 bytes stored after retry");

    // R6 persistent error reaches block deadline
    fill(8); err_n = 100000;
    run_job(32'h60000, 3, 2, 0);
    chk(prog_cnt - job_base > 2, "R6 retried until deadline", prog_cnt - job_base, 3);
    err_n = 0;

    // R5 ordering of read mode before clear
    chk(order_viol == 0, "R5 read mode before clear", order_viol, 0);

    // R7 verify mismatch
    fill(9); corrupt_addr = 32'h70002;
    run_job(32'h70000, 4, 1, 0);
    corrupt_addr = -1;

    // R10 zero length
    ops0 = bus_ops; p0 = prog_cnt;
    run_job(32'h80000, 0, 0, 0);
    chk(bus_ops == ops0, "R10 zero length has no bus access", bus_ops - ops0, 0);

    // R10 start ignored while busy
    fill(10); slow = 2;
    begin
      int d0;
      exp_t e;
      d0 = done_cnt;
      e.code = 0; e.cnt = 6;
      exp_q.push_back(e);
      job_base = prog_cnt;
      @(negedge clk);
      start_addr = ADDR_W'(32'h90000); start_len = CNT_W'(6); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start_addr = ADDR_W'(32'h91000); start_len = CNT_W'(3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == d0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 single completion", done_cnt - d0, 1);
      chk(!fmem.exists(32'h91000), "R10 second start ignored", fmem.exists(32'h91000), 0);
      chk_mem(32'h90000, 6, "R10 first job intact");
    end

    // R9 R2 gate and alignment seen by the device
    chk(gate_viol == 0, "R9 kick before each command", gate_viol, 0);
    chk(align_viol == 0, "R2 word-aligned program writes", align_viol, 0);
    chk(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule